// File: doc/BRIEF.md
# Dual-Lane 7:1 Parallel Serializer

This block takes a 14-bit parallel word once per frame and sends it out as two serial lanes of seven bits each, together with a forwarded frame clock. It runs on a bit clock that is seven times the frame rate. A one-cycle frame strobe marks each frame boundary, and the block derives its frame phase and the forwarded clock from that strobe. It contains no clock multiplier.

The word is sampled at one of two points in the frame. With the edge select high, the sample is taken at the frame clock's rising edge, which is the bit-clock edge where the strobe is seen. With the edge select low, it is taken at the frame clock's falling edge. The sampled word waits in a holding register until the next frame boundary. There it is loaded into the lane shifters.

A high enable lets the block run. A low enable clears all internal state and drops the output-valid flag, which stands in for a high-impedance output. Loss of the strobe parks the block in an idle phase. When the strobe returns, operation resumes without an enable cycle.

Top module: `ser7_dual_lane`

## Requirements
- R1: Lane 0 carries data bits 0..6 and lane 1 carries data bits 7..13 of the same captured word.
- R2: Each lane sends one bit per bit clock and seven bits per frame, bit 6 of its slice first and bit 0 last.
- R3: With edge_sel_i high, the word is captured on the bit-clock edge where frame_strobe_i is sampled high.
- R4: With edge_sel_i low, the word is captured on the fourth bit-clock edge after the strobe edge, which is the falling edge of the forwarded clock.
- R5: A word captured in frame n is shifted out during frame n+1. Its first bit appears in the bit period that follows the next strobe edge.
- R6: fclk_o is high for the 4 bit periods that follow a strobe edge and low for the remaining 3, so its rising edge marks the first bit of each frame.
- R7: While en_i is sampled low, out_valid_o, fclk_o and both lanes are 0 from the next edge, and the capture, phase and shift state is cleared.
- R8: After reset or after enable rises, the lanes output 0 until the first captured word has been loaded.
- R9: Without a strobe, the block idles after the current frame with fclk_o low and lanes at 0, keeping the held word. The next strobe resumes output with that word, with no enable cycle.
- R10: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the frame rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low clears the block and invalidates outputs |
| edge_sel_i | input | 1 | Capture edge: 1 = frame rising edge, 0 = frame falling edge |
| frame_strobe_i | input | 1 | One-cycle frame boundary marker |
| data_i | input | 14 | Parallel word; bits 0..6 go to lane 0, bits 7..13 go to lane 1 |
| lane_o | output | 2 | Serial lane outputs, MSB of each slice first |
| fclk_o | output | 1 | Forwarded frame clock |
| out_valid_o | output | 1 | Output-valid flag; low models high impedance |

## Verification
The bench builds the block with its defaults: seven bits per lane, two lanes, and a forwarded clock that is high for four bit periods. At this size, every bit slot of every frame can be compared against an arithmetically generated word stream. This is done for both capture-edge settings. The bench changes the input word between the falling-edge sample point and the next strobe, which separates the two capture points while keeping the same one-frame latency. A strobe gap in mid-stream exercises the idle and resume path, and the enable is pulsed low between the two runs to show that state is cleared.

// File: rtl/ser7_pkg.sv
package ser7_pkg;
  typedef enum logic {
    CAP_FALL = 1'b0,
    CAP_RISE = 1'b1
  } cap_edge_e;
endpackage

// File: rtl/ser7_frame_phase.sv
module ser7_frame_phase #(
  parameter int BITS      = 7,
  parameter int HIGH_BITS = 4,
  localparam int PW       = $clog2(BITS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          strobe_i,
  output logic [PW-1:0] phase_o,
  output logic          fclk_o,
  output logic          fall_evt_o
);
  localparam logic [PW-1:0] IDLE = PW'(BITS);
  localparam logic [PW-1:0] HIGH = PW'(HIGH_BITS);

  logic [PW-1:0] phase_q;

  // phase counts 0..BITS-1 after a strobe, then parks at IDLE
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_q <= IDLE;
    else if (clr_i)            phase_q <= IDLE;
    else if (strobe_i)         phase_q <= '0;
    else if (phase_q != IDLE)  phase_q <= phase_q + 1'b1;
  end

  assign phase_o    = phase_q;
  assign fclk_o     = (phase_q < HIGH);
  assign fall_evt_o = (phase_q == HIGH - 1'b1);

  assert_idle_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !strobe_i && phase_q == IDLE) |=> (phase_q == IDLE));
  assert_strobe_starts_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && strobe_i) |=> fclk_o);
endmodule

// File: rtl/ser7_word_capture.sv
module ser7_word_capture #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         edge_sel_i,
  input  logic         rise_evt_i,
  input  logic         fall_evt_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  import ser7_pkg::*;

  cap_edge_e edge_sel;
  logic      cap;
  logic [W-1:0] word_q;
  logic         valid_q;

  assign edge_sel = cap_edge_e'(edge_sel_i);
  assign cap      = (edge_sel == CAP_RISE) ? rise_evt_i : fall_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else if (clr_i) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else if (cap) begin
      word_q  <= data_i;
      valid_q <= 1'b1;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  assert_rise_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && edge_sel_i && rise_evt_i) |=> (word_o == $past(data_i)));
  assert_fall_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !edge_sel_i && fall_evt_i) |=> (word_o == $past(data_i)));
  assert_clear_invalidates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_o);
endmodule

// File: rtl/ser7_lane_shift.sv
module ser7_lane_shift #(
  parameter int BITS = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic            word_ok_i,
  input  logic [BITS-1:0] word_i,
  output logic            ser_o
);
  logic [BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (clr_i)  sh_q <= '0;
    else if (load_i) sh_q <= word_ok_i ? word_i : '0;
    else             sh_q <= {sh_q[BITS-2:0], 1'b0};
  end

  assign ser_o = sh_q[BITS-1];

  assert_msb_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_i && word_ok_i) |=> (ser_o == $past(word_i[BITS-1])));
  assert_zero_before_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_i && !word_ok_i) |=> !ser_o);
endmodule

// File: rtl/ser7_dual_lane.sv
module ser7_dual_lane #(
  parameter int BITS      = 7,
  parameter int LANES     = 2,
  parameter int HIGH_BITS = 4,
  localparam int W        = BITS * LANES,
  localparam int PW       = $clog2(BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             edge_sel_i,
  input  logic             frame_strobe_i,
  input  logic [W-1:0]     data_i,
  output logic [LANES-1:0] lane_o,
  output logic             fclk_o,
  output logic             out_valid_o
);
  logic          en_q;
  logic          clr;
  logic [PW-1:0] phase;
  logic          fclk_int;
  logic          fall_evt;
  logic [W-1:0]  held_word;
  logic          held_ok;
  logic [LANES-1:0] ser;

  assign clr = !en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  ser7_frame_phase #(.BITS(BITS), .HIGH_BITS(HIGH_BITS)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .strobe_i   (frame_strobe_i),
    .phase_o    (phase),
    .fclk_o     (fclk_int),
    .fall_evt_o (fall_evt)
  );

  ser7_word_capture #(.W(W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .edge_sel_i (edge_sel_i),
    .rise_evt_i (frame_strobe_i),
    .fall_evt_i (fall_evt),
    .data_i     (data_i),
    .word_o     (held_word),
    .valid_o    (held_ok)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ser7_lane_shift #(.BITS(BITS)) u_sh (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .load_i    (frame_strobe_i),
      .word_ok_i (held_ok),
      .word_i    (held_word[g*BITS +: BITS]),
      .ser_o     (ser[g])
    );
  end

  assign lane_o      = ser & {LANES{en_q}};
  assign fclk_o      = fclk_int & en_q;
  assign out_valid_o = en_q;

  assert_disable_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!out_valid_o && !fclk_o && lane_o == '0));
  assert_fclk_rise_on_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fclk_o) |-> $past(frame_strobe_i));
  assert_fclk_low_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PW'(BITS)) |-> !fclk_o);
  always_comb begin
    if (!rst_ni) assert_reset_outputs_R10: assert (lane_o == '0 && !fclk_o && !out_valid_o);
  end
endmodule

// File: tb/ser7_dual_lane_tb.sv
module ser7_dual_lane_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        edge_sel_i = 1'b1;
  logic        frame_strobe_i = 1'b0;
  logic [13:0] data_i = '0;
  logic [1:0]  lane_o;
  logic        fclk_o;
  logic        out_valid_o;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  ser7_dual_lane dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .edge_sel_i(edge_sel_i),
    .frame_strobe_i(frame_strobe_i), .data_i(data_i),
    .lane_o(lane_o), .fclk_o(fclk_o), .out_valid_o(out_valid_o)
  );

  function automatic logic [13:0] word_of(int f, int mode);
    logic [13:0] w;
    if (f % 16 == 3)      w = 14'h3FFF;
    else if (f % 16 == 7) w = 14'h0000;
    else w = 14'((f * 1237) ^ (f << 3) ^ (mode * 14'h2AAA) ^ (1 << (f % 14)));
    return w;
  endfunction

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {out_valid_o, fclk_o, lane_o[1], lane_o[0]};
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act={valid,fclk,l1,l0}=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic stb, logic [13:0] d);
    frame_strobe_i = stb;
    data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run_mode(int mode);
    string rq;
    logic [13:0] prev;
    rq = (mode == 1) ? "R3 R1 R2 R5" : "R4 R1 R2 R5";
    // disabled: strobes and data ignored (R7)
    en_i = 1'b0;
    for (int i = 0; i < 9; i++) begin
      step(i % 7 == 0, 14'h1555 ^ 14'(i));
      chk("R7 disabled", 4'b0000);
    end
    edge_sel_i = mode[0];
    en_i = 1'b1;
    step(1'b0, word_of(0, mode));
    chk("R8 enabled idle", 4'b1000);
    for (int f = 0; f < 24; f++) begin
      if (f == 10) begin
        for (int i = 0; i < 9; i++) begin
          step(1'b0, word_of(f, mode));
          chk("R9 strobe gap", 4'b1000);
        end
      end
      prev = (f == 0) ? 14'h0 : word_of(f - 1, mode);
      for (int s = 0; s < 7; s++) begin
        step(s == 0, (s <= 4) ? word_of(f, mode) : word_of(f + 1, mode));
        if (f == 0)
          chk("R8 first frame zero", {1'b1, s < 4, 2'b00});
        else
          chk((f == 10) ? "R9 resume" : rq,
              {1'b1, s < 4, prev[13 - s], prev[6 - s]});
        if (f > 0 && s == 0) chk("R6 fclk rise at frame start", {1'b1, 1'b1, prev[13], prev[6]});
      end
    end
  endtask

  initial begin
    @(negedge clk_i);
    chk("R10 reset", 4'b0000);
    frame_strobe_i = 1'b1;
    data_i = 14'h3FFF;
    en_i = 1'b1;
    @(negedge clk_i);
    chk("R10 reset held", 4'b0000);
    en_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_mode(1);
    run_mode(0);
    en_i = 1'b0;
    step(1'b1, 14'h3FFF);
    chk("R7 disable after run", 4'b0000);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule